// File: doc/BRIEF.md
# Local and Remote Wake-Up Detector

This block watches two slow inputs of a bus transceiver while it sits in a low-power state, and raises a wake-up flag when either input shows a genuine request. The first input is a wake pin. Any change of its level counts as a local request once the new level has held long enough. The second input is the received bus level. A remote request needs a four-phase bus pattern: a long enough dominant phase, a long enough recessive phase, then a second dominant phase and a second recessive phase, each with its own minimum. Both inputs pass through a synchroniser before any filtering, and all minimum times are parameters counted in clock cycles.

The flag can only be raised in the low-power modes, and never while the undervoltage waiting window is open. When the flag is raised, a one-cycle pulse tells the undervoltage logic to clear its flag and timers. A source output records which detector raised the flag. The flag is cleared when the transceiver returns to Normal mode. The remote pattern search also starts over while the transceiver is in Normal mode, so bus traffic seen there cannot count towards a wake-up.

Top module: `wkup_detect`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, `wakeFlag`, `wakeSrcRemote` and `uvClearPulse` are all 0. After reset, the wake pin's reference level is low and the bus is taken as recessive.
- R2: A local hit occurs when the synchronised `wakePin` differs from its reference level for LOCAL_CYC consecutive cycles. The hit works in both directions, and the new level then becomes the reference. A change that lasts LOCAL_CYC-1 cycles or less leaves the reference unchanged.
- R3: A remote hit occurs after this sequence on `busDom` (1 = dominant, 0 = recessive): a dominant phase of at least DOM_CYC cycles, a recessive phase of at least REC_CYC cycles, a second dominant phase of at least DOM_CYC cycles, and a second recessive phase of at least REC_CYC cycles.
- R4: The remote search starts again from the beginning in two cases: a recessive phase ends early (under REC_CYC) while the search waits on it, or the second dominant phase is shorter than DOM_CYC. A short first dominant phase is simply not counted.
- R5: A hit sets `wakeFlag` only when `opMode` is Standby (3'b010), Go-to-sleep (3'b011) or Sleep (3'b100). In Normal (3'b000), Listen-only (3'b001) and the unused codes it has no effect.
- R6: While `uvWait` is 1, hits are discarded. They are not held back to set the flag later.
- R7: `uvClearPulse` is 1 for exactly one cycle: the first cycle in which `wakeFlag` reads 1. Further hits while the flag is set produce no pulse.
- R8: `wakeFlag` reads 0 in the cycle after any cycle in which `opMode` is Normal. It holds its value in all other modes. The remote search is held at its start while in Normal.
- R9: `wakeSrcRemote` is 0 for a local wake and 1 for a remote wake. It records the detector that set the flag; if both fire in the same cycle, local wins. It holds while the flag stays set.
- R10: With SYNC_STAGES synchroniser stages, take the first clock edge that samples a changed `wakePin` as edge 0. `wakeFlag` first reads 1 after edge LOCAL_CYC+SYNC_STAGES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wakePin | input | 1 | Wake pin level, asynchronous |
| busDom | input | 1 | Received bus level, 1 = dominant, asynchronous |
| opMode | input | 3 | Operating mode code |
| uvWait | input | 1 | Undervoltage waiting window active |
| wakeFlag | output | 1 | Wake-up flag |
| wakeSrcRemote | output | 1 | Source of the wake: 0 local, 1 remote |
| uvClearPulse | output | 1 | One-cycle request to clear the undervoltage flag and timers |

## Verification
The bench probes phase lengths exactly one cycle either side of each minimum. A design that counts from the wrong edge would accept a pulse one cycle short or reject one of exactly the minimum length. It places a short recessive phase and a short second dominant phase inside otherwise valid patterns. A design that only skips the bad phase, instead of restarting, would then wake on the remainder. It times a local change to complete in the same cycle as a remote pattern, which shows whether the source priority is right. It also raises hits during the undervoltage window and in Listen-only mode, to catch a design that holds a pending hit and sets the flag later. Randomised phase and pulse lengths are compared against a phase-level model kept in the bench.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  localparam logic [2:0] MODE_NORMAL  = 3'b000;
  localparam logic [2:0] MODE_LISTEN  = 3'b001;
  localparam logic [2:0] MODE_STANDBY = 3'b010;
  localparam logic [2:0] MODE_GOSLEEP = 3'b011;
  localparam logic [2:0] MODE_SLEEP   = 3'b100;

  // Events from the datapath to the control
  typedef struct packed {
    logic localHit;   // wake pin change qualified
    logic domDone;    // dominant run of sufficient length just ended
    logic domShort;   // dominant run ended too early
    logic recDone;    // recessive run has just reached its minimum
    logic recShort;   // recessive run ended too early
  } det_ev_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic setLocal;
    logic setRemote;
    logic clrFlag;
  } flag_cmd_t;

  typedef enum logic [1:0] {
    SEEK_DOM1 = 2'd0,
    WAIT_REC1 = 2'd1,
    SEEK_DOM2 = 2'd2,
    WAIT_REC2 = 2'd3
  } rpat_e;

  function automatic logic isLowPower(input logic [2:0] m);
    return (m == MODE_STANDBY) || (m == MODE_GOSLEEP) || (m == MODE_SLEEP);
  endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES:0] chain;

  assign chain[0] = d;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[STAGES:1] <= '0;
    else       chain[STAGES:1] <= chain[STAGES-1:0];
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/wkup_datapath.sv
module wkup_datapath
  import wkup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCAL_CYC   = 16,
  parameter int DOM_CYC     = 12,
  parameter int REC_CYC     = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wakePin,
  input  logic      busDom,
  input  flag_cmd_t cmd,
  output det_ev_t   ev,
  output logic      wakeFlag,
  output logic      wakeSrcRemote,
  output logic      uvClearPulse
);
  localparam int LOC_W   = $clog2(LOCAL_CYC + 1);
  localparam int RUN_MAX = ((DOM_CYC > REC_CYC) ? DOM_CYC : REC_CYC) + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic wakeS, busS;

  wkup_sync #(.STAGES(SYNC_STAGES)) wakeSync_i (
    .clk(clk), .rstN(rstN), .d(wakePin), .q(wakeS));
  wkup_sync #(.STAGES(SYNC_STAGES)) busSync_i (
    .clk(clk), .rstN(rstN), .d(busDom), .q(busS));

  // Local filter: count cycles the pin differs from its reference
  logic             refLvl;
  logic [LOC_W-1:0] locCnt;
  logic             pinDiffers;

  assign pinDiffers  = (wakeS != refLvl);
  assign ev.localHit = pinDiffers && (locCnt == LOC_W'(LOCAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLvl <= 1'b0;
      locCnt <= '0;
    end else if (!pinDiffers) begin
      locCnt <= '0;
    end else if (ev.localHit) begin
      locCnt <= '0;
      refLvl <= wakeS;
    end else begin
      locCnt <= locCnt + 1'b1;
    end
  end

  // Bus run-length measurement: runCnt is the length of the busPrev run
  logic             busPrev;
  logic [RUN_W-1:0] runCnt;
  logic             busEdge;

  assign busEdge = (busS != busPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPrev <= 1'b0;
      runCnt  <= '0;
    end else begin
      busPrev <= busS;
      if (busEdge)                        runCnt <= RUN_W'(1);
      else if (runCnt != RUN_W'(RUN_MAX)) runCnt <= runCnt + 1'b1;
    end
  end

  assign ev.domDone  = busEdge &&  busPrev && (runCnt >= RUN_W'(DOM_CYC));
  assign ev.domShort = busEdge &&  busPrev && (runCnt <  RUN_W'(DOM_CYC));
  assign ev.recShort = busEdge && !busPrev && (runCnt <  RUN_W'(REC_CYC));
  assign ev.recDone  = !busPrev && (runCnt == RUN_W'(REC_CYC));

  // Flag, source and clear pulse registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeFlag      <= 1'b0;
      wakeSrcRemote <= 1'b0;
      uvClearPulse  <= 1'b0;
    end else begin
      uvClearPulse <= 1'b0;
      if (cmd.clrFlag) begin
        wakeFlag      <= 1'b0;
        wakeSrcRemote <= 1'b0;
      end else if (cmd.setLocal) begin
        wakeFlag      <= 1'b1;
        wakeSrcRemote <= 1'b0;
        uvClearPulse  <= 1'b1;
      end else if (cmd.setRemote) begin
        wakeFlag      <= 1'b1;
        wakeSrcRemote <= 1'b1;
        uvClearPulse  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
  import wkup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opMode,
  input  logic       uvWait,
  input  det_ev_t    ev,
  input  logic       flagNow,
  output flag_cmd_t  cmd
);
  rpat_e patQ, patD;
  logic  remoteHit;
  logic  inNormal;
  logic  canSet;

  assign inNormal  = (opMode == MODE_NORMAL);
  assign remoteHit = (patQ == WAIT_REC2) && ev.recDone;
  assign canSet    = isLowPower(opMode) && !uvWait && !flagNow;

  always_comb begin
    patD = patQ;
    unique case (patQ)
      SEEK_DOM1: if (ev.domDone) patD = WAIT_REC1;
      WAIT_REC1: begin
        if (ev.recDone)       patD = SEEK_DOM2;
        else if (ev.recShort) patD = SEEK_DOM1;
      end
      SEEK_DOM2: begin
        if (ev.domDone)       patD = WAIT_REC2;
        else if (ev.domShort) patD = SEEK_DOM1;
      end
      WAIT_REC2: if (ev.recDone || ev.recShort) patD = SEEK_DOM1;
      default: patD = SEEK_DOM1;
    endcase
    if (inNormal) patD = SEEK_DOM1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) patQ <= SEEK_DOM1;
    else       patQ <= patD;
  end

  assign cmd.setLocal  = canSet && ev.localHit;
  assign cmd.setRemote = canSet && remoteHit && !ev.localHit;
  assign cmd.clrFlag   = inNormal;
endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
  import wkup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCAL_CYC   = 16,
  parameter int DOM_CYC     = 12,
  parameter int REC_CYC     = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakePin,
  input  logic       busDom,
  input  logic [2:0] opMode,
  input  logic       uvWait,
  output logic       wakeFlag,
  output logic       wakeSrcRemote,
  output logic       uvClearPulse
);
  det_ev_t   ev;
  flag_cmd_t cmd;

  wkup_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .LOCAL_CYC(LOCAL_CYC),
    .DOM_CYC(DOM_CYC), .REC_CYC(REC_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wakePin(wakePin), .busDom(busDom),
    .cmd(cmd), .ev(ev), .wakeFlag(wakeFlag),
    .wakeSrcRemote(wakeSrcRemote), .uvClearPulse(uvClearPulse)
  );

  wkup_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opMode(opMode), .uvWait(uvWait),
    .ev(ev), .flagNow(wakeFlag), .cmd(cmd)
  );
endmodule

// File: rtl/wkup_detect_chk.sv
module wkup_detect_chk
  import wkup_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] opMode,
  input logic       uvWait,
  input logic       wakeFlag,
  input logic       wakeSrcRemote,
  input logic       uvClearPulse
);
  logic lowPow;
  assign lowPow = isLowPower(opMode);

  // R5: flag rises only after a low-power mode cycle
  a_r5_set_lowpower: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(lowPow));

  // R6: flag never rises out of a waiting-window cycle
  a_r6_uv_block: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> !$past(uvWait));

  // R7: pulse coincides with the flag's rise
  a_r7_pulse_with_rise: assert property (@(posedge clk) disable iff (!rstN)
    uvClearPulse |-> (wakeFlag && !$past(wakeFlag)));

  a_r7_rise_has_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> uvClearPulse);

  // R8: Normal mode clears the flag
  a_r8_normal_clears: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_NORMAL) |=> !wakeFlag);

  // R8: flag only falls after a Normal cycle
  a_r8_hold_elsewhere: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeFlag) |-> ($past(opMode) == MODE_NORMAL));

  // R9: source held while flag stays set
  a_r9_src_held: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && $past(wakeFlag)) |-> $stable(wakeSrcRemote));
endmodule

bind wkup_detect wkup_detect_chk chk_i (
  .clk(clk), .rstN(rstN), .opMode(opMode), .uvWait(uvWait),
  .wakeFlag(wakeFlag), .wakeSrcRemote(wakeSrcRemote),
  .uvClearPulse(uvClearPulse)
);

// File: tb/wkup_detect_tb.sv
module wkup_detect_tb_top;
  localparam int SYNC = 2;
  localparam int LC   = 16;
  localparam int DC   = 12;
  localparam int RC   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakePin = 1'b0;
  logic busDom = 1'b0;
  logic [2:0] opMode = 3'b000;
  logic uvWait = 1'b0;
  logic wakeFlag, wakeSrcRemote, uvClearPulse;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wkup_detect #(.SYNC_STAGES(SYNC), .LOCAL_CYC(LC), .DOM_CYC(DC), .REC_CYC(RC)) dut_i (
    .clk(clk), .rstN(rstN), .wakePin(wakePin), .busDom(busDom),
    .opMode(opMode), .uvWait(uvWait), .wakeFlag(wakeFlag),
    .wakeSrcRemote(wakeSrcRemote), .uvClearPulse(uvClearPulse));

  always @(negedge clk) if (rstN && uvClearPulse) pulseCnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    opMode = m;
    tick(1);
  endtask

  task automatic clearAll();
    opMode = 3'b000;
    busDom = 1'b0;
    tick(LC + 6);
  endtask

  task automatic pulsePin(input int n);
    wakePin = ~wakePin;
    tick(n);
    wakePin = ~wakePin;
  endtask

  task automatic phase(input logic lvl, input int n);
    busDom = lvl;
    tick(n);
  endtask

  // Bench model of the remote pattern over alternating dom/rec phases
  function automatic bit remoteModel(input int d[4], input int r[4], input int np);
    int st = 0;
    bit hit = 0;
    for (int i = 0; i < np; i++) begin
      if (st == 0) begin
        if (d[i] >= DC) st = 1;
      end else if (st == 2) begin
        st = (d[i] >= DC) ? 3 : 0;
      end
      if (st == 1) st = (r[i] >= RC) ? 2 : 0;
      else if (st == 3) begin
        if (r[i] >= RC) hit = 1;
        st = 0;
      end
    end
    return hit;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int p0;
    void'($urandom(32'd20240601));
    tick(3);
    // R1 reset state
    chk("R1 flag in reset", wakeFlag, 0);
    chk("R1 src in reset", wakeSrcRemote, 0);
    chk("R1 pulse in reset", uvClearPulse, 0);
    rstN = 1'b1;
    tick(1);
    chk("R1 flag after reset", wakeFlag, 0);

    // R10 exact latency, R7 pulse, R9 local source
    setMode(3'b010);
    tick(4);
    p0 = pulseCnt;
    wakePin = 1'b1;
    tick(LC + SYNC - 1);
    chk("R10 flag before latency", wakeFlag, 0);
    tick(1);
    chk("R10 flag at latency", wakeFlag, 1);
    chk("R7 pulse with rise", uvClearPulse, 1);
    chk("R9 local source", wakeSrcRemote, 0);
    tick(1);
    chk("R7 pulse one cycle", uvClearPulse, 0);

    // R8 Normal clears; R5 Normal does not set
    opMode = 3'b000;
    tick(1);
    chk("R8 cleared after Normal", wakeFlag, 0);
    wakePin = 1'b0;
    tick(LC + 6);
    chk("R5 Normal no set", wakeFlag, 0);

    // R2 boundary lengths
    setMode(3'b010);
    tick(3);
    pulsePin(LC - 1);
    tick(LC + 6);
    chk("R2 short pulse ignored", wakeFlag, 0);
    p0 = pulseCnt;
    pulsePin(LC);
    tick(LC + 6);
    chk("R2 exact pulse wakes", wakeFlag, 1);
    chk("R7 one pulse for two hits", pulseCnt - p0, 1);

    // R8 Listen-only holds the flag
    setMode(3'b001);
    tick(5);
    chk("R8 held in listen", wakeFlag, 1);
    clearAll();
    // R5 Listen-only cannot set
    setMode(3'b001);
    wakePin = 1'b1;
    tick(LC + 6);
    chk("R5 listen no set", wakeFlag, 0);
    setMode(3'b010);
    tick(LC + 6);
    chk("R5 listen hit not kept", wakeFlag, 0);

    // R6 undervoltage window
    uvWait = 1'b1;
    wakePin = 1'b0;
    tick(LC + 6);
    chk("R6 blocked in window", wakeFlag, 0);
    uvWait = 1'b0;
    tick(LC + 6);
    chk("R6 hit discarded", wakeFlag, 0);

    // R5 go-to-sleep, sleep, unused code
    setMode(3'b011);
    wakePin = 1'b1;
    tick(LC + 6);
    chk("R5 gosleep sets", wakeFlag, 1);
    clearAll();
    setMode(3'b100);
    wakePin = 1'b0;
    tick(LC + 6);
    chk("R5 sleep sets", wakeFlag, 1);
    clearAll();
    setMode(3'b101);
    wakePin = 1'b1;
    tick(LC + 6);
    chk("R5 unused code no set", wakeFlag, 0);
    clearAll();

    // R3 remote, R9 remote source kept against later local
    setMode(3'b010);
    phase(1, DC); phase(0, RC); phase(1, DC); phase(0, RC + 6);
    chk("R3 remote wake", wakeFlag, 1);
    chk("R9 remote source", wakeSrcRemote, 1);
    wakePin = ~wakePin;
    tick(LC + 6);
    chk("R9 source held", wakeSrcRemote, 1);
    clearAll();

    // R3 short first dominant not counted
    setMode(3'b010);
    phase(1, DC - 1); phase(0, RC); phase(1, DC); phase(0, RC + 6);
    chk("R3 short first dom", wakeFlag, 0);
    clearAll();

    // R4 short recessive restarts
    setMode(3'b010);
    phase(1, DC); phase(0, RC - 1); phase(1, DC); phase(0, RC + 6);
    chk("R4 short rec restarts", wakeFlag, 0);
    phase(1, DC); phase(0, RC + 6);
    chk("R4 wake after restart", wakeFlag, 1);
    clearAll();

    // R4 short second dominant restarts
    setMode(3'b010);
    phase(1, DC); phase(0, RC); phase(1, DC - 1); phase(0, RC);
    phase(1, DC); phase(0, RC + 6);
    chk("R4 short dom2 restarts", wakeFlag, 0);
    clearAll();

    // R8 search restarts in Normal
    phase(1, DC); phase(0, RC + 4);
    setMode(3'b010);
    phase(1, DC); phase(0, RC + 6);
    chk("R8 Normal resets search", wakeFlag, 0);
    phase(1, DC); phase(0, RC + 6);
    chk("R8 wake after Normal reset", wakeFlag, 1);
    clearAll();

    // R9 simultaneous hits: local wins
    setMode(3'b010);
    phase(1, DC); phase(0, RC); phase(1, DC - (LC - RC - 1));
    wakePin = ~wakePin;
    phase(1, LC - RC - 1);
    phase(0, RC + 6);
    chk("R9 simultaneous flag", wakeFlag, 1);
    chk("R9 simultaneous local wins", wakeSrcRemote, 0);
    clearAll();

    // Random remote patterns against the model (R3, R4)
    for (int t = 0; t < 24; t++) begin
      int d[4];
      int r[4];
      bit exp;
      for (int i = 0; i < 4; i++) begin
        d[i] = DC - 2 + int'($urandom_range(4));
        r[i] = RC - 2 + int'($urandom_range(4));
      end
      r[3] = RC + 3;
      exp = remoteModel(d, r, 4);
      setMode(3'b010);
      for (int i = 0; i < 4; i++) begin
        phase(1, d[i]);
        phase(0, r[i]);
      end
      tick(4);
      chk("R3 R4 random remote", wakeFlag, exp);
      if (exp) chk("R9 random remote src", wakeSrcRemote, 1);
      clearAll();
    end

    // Random local pulses (R2)
    for (int t = 0; t < 24; t++) begin
      int len;
      len = LC - 3 + int'($urandom_range(6));
      setMode(3'b010);
      pulsePin(len);
      tick(LC + 6);
      chk("R2 random local", wakeFlag, (len >= LC) ? 1 : 0);
      clearAll();
    end

    summary();
  end
endmodule